// File: doc/BRIEF.md
# Selectable Ratio Reference Divider

This block divides a reference clock down to the comparison rate that a phase comparator consumes. It produces a one-cycle strobe once per divided period. A 4-bit ratio code picks one of sixteen division ratios. The code has a family bit and a 3-bit select field. With the family bit clear, the ratios are powers of two. With the family bit set, the ratios follow a series that starts at three and five and then doubles at each step.

A single down-counter does the division. The ratio code is sampled only at the terminal count. Software can therefore rewrite the code at any time, and the current period is never shortened or stretched. After reset is released the counter loads the ratio of the code present at that moment, and the first strobe follows one full period later.

Top module: `ref_ratio_divider`

## Requirements
- R1: Code bit 3 is the family bit and bits 2:0 are the select value s. With bit 3 = 0 the division ratio is 2^(s+1): s = 0 to 7 give 2, 4, 8, 16, 32, 64, 128 and 256.
- R2: With code bit 3 = 1, select 0 gives ratio 3 and select s ≥ 1 gives 5·2^(s-1): s = 0 to 7 give 3, 5, 10, 20, 40, 80, 160 and 320.
- R3: The strobe is high for exactly one clock cycle per divided period and is never high in two consecutive cycles.
- R4: Counting the first rising edge with reset high as edge 1, the first strobe is high in the cycle that follows edge N. N is the ratio of the code applied at reset release.
- R5: The code is sampled only in a strobe cycle. A change of code in the middle of a period leaves that period's length unchanged. The new ratio applies from the next period.
- R6: While reset is low the strobe is low. A reset in the middle of a period discards the partial count, and timing restarts as in R4.
- R7: In steady state, consecutive strobes are exactly ratio cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Bit 3 family, bits 2:0 select, held in a shadow register |
| cmp_strobe | output | 1 | One-cycle comparison strobe per divided period |

## Verification
The assertions check on every cycle that the strobe is never high two cycles in a row and that the latched ratio stays fixed between strobes. They also check that the count stays below the latched ratio and that each decoded ratio belongs to its family. The exact ratio for each of the sixteen codes, the timing of the first strobe after reset, the deferral of a code change made mid-period, and the restart after a reset mid-period can only be shown by the bench. Its scenarios predict the cycle of every strobe and compare it with the strobe the design produces.

// File: rtl/ref_ratio_pkg.sv
package ref_ratio_pkg;

    typedef enum logic {
        FAMILY_BINARY = 1'b0,
        FAMILY_FIVE   = 1'b1
    } ratio_family_e;

    // Ratio for one family/select pair.
    function automatic int unsigned ratio_value(input int unsigned family, input int unsigned sel);
        int unsigned r;
        if (family == 0) begin
            r = 2 << sel;
        end else if (sel == 0) begin
            r = 3;
        end else begin
            r = 5 << (sel - 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ref_ratio_decode.sv
module ref_ratio_decode
    import ref_ratio_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int RAT_W = 9
) (
    input  logic [SEL_W:0]   code_i,
    output logic [RAT_W-1:0] ratio_o
);

    localparam int N_SEL  = 1 << SEL_W;
    localparam int N_CODE = 2 * N_SEL;

    logic [RAT_W-1:0] table_w [N_CODE];

    // Lookup table built for both families.
    for (genvar fam = 0; fam < 2; fam++) begin : g_family
        for (genvar s = 0; s < N_SEL; s++) begin : g_sel
            assign table_w[fam*N_SEL + s] = RAT_W'(ratio_value(fam, s));
        end
    end

    assign ratio_o = table_w[code_i];

    always_comb begin
        if (ratio_family_e'(code_i[SEL_W]) == FAMILY_BINARY) begin
            assert_binary_pow2_R1: assert ($countones(ratio_o) == 1 && ratio_o >= RAT_W'(2));
        end else begin
            assert_five_series_R2: assert (ratio_o == RAT_W'(3) || (ratio_o % 5) == 0);
        end
    end

endmodule

// File: rtl/ref_ratio_counter.sv
module ref_ratio_counter #(
    parameter int RAT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAT_W-1:0] ratio_i,
    output logic             strobe_o
);

    typedef struct packed {
        logic [RAT_W-1:0] count;
        logic [RAT_W-1:0] ratio;
        logic             started;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       terminal_w;

    always_comb begin
        st_d       = st_q;
        terminal_w = st_q.started && (st_q.count == '0);
        if (!st_q.started || terminal_w) begin
            st_d.started = 1'b1;
            st_d.ratio   = ratio_i;
            st_d.count   = ratio_i - RAT_W'(1);
        end else begin
            st_d.count = st_q.count - RAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = terminal_w;

    assert_single_cycle_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_ratio_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && !strobe_o) |=> $stable(st_q.ratio));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started |-> (st_q.count < st_q.ratio));

endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider #(
    parameter int SEL_W = 3
) (
    input  logic         clk_ref,
    input  logic         rst_n,
    input  logic [SEL_W:0] ratio_code,
    output logic         cmp_strobe
);

    localparam int MAX_RATIO = 5 << ((1 << SEL_W) - 2);
    localparam int RAT_W     = $clog2(MAX_RATIO + 1);

    logic [RAT_W-1:0] ratio_w;

    ref_ratio_decode #(
        .SEL_W (SEL_W),
        .RAT_W (RAT_W)
    ) u_decode (
        .code_i  (ratio_code),
        .ratio_o (ratio_w)
    );

    ref_ratio_counter #(
        .RAT_W (RAT_W)
    ) u_counter (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .ratio_i  (ratio_w),
        .strobe_o (cmp_strobe)
    );

endmodule

// File: tb/ref_ratio_divider_bench.sv
module ref_ratio_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       strobe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t_ref = 0;
    int exp_q[$];
    string exp_tag[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    ref_ratio_divider u_ref_ratio_divider (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .ratio_code (code),
        .cmp_strobe (strobe)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic int model_ratio(input logic [3:0] c);
        case (c)
            4'd0: return 2;    4'd1: return 4;    4'd2: return 8;    4'd3: return 16;
            4'd4: return 32;   4'd5: return 64;   4'd6: return 128;  4'd7: return 256;
            4'd8: return 3;    4'd9: return 5;    4'd10: return 10;  4'd11: return 20;
            4'd12: return 40;  4'd13: return 80;  4'd14: return 160; default: return 320;
        endcase
    endfunction

    // Monitor: pops expected strobe cycles and compares.
    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R3: unexpected strobe at cycle %0d (actual 1, expected 0)", cyc);
                end else begin
                    int e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = exp_tag.pop_front();
                    if (e != cyc) begin
                        failures++;
                        $display("FAIL %s: strobe at cycle %0d, expected %0d", tg, cyc, e);
                    end
                end
            end else if (exp_q.size() != 0 && cyc >= exp_q[0]) begin
                string tg;
                checks++;
                failures++;
                tg = exp_tag.pop_front();
                $display("FAIL %s: no strobe at cycle %0d (actual 0, expected 1 at %0d)", tg, cyc, exp_q.pop_front());
            end
        end
    end

    task automatic wait_ref();
        while (cyc != t_ref) @(negedge clk);
    endtask

    // Driver: apply code at a period boundary and push expected strobes.
    task automatic play(input logic [3:0] c, input int n, input string tg);
        code = c;
        for (int i = 0; i < n; i++) begin
            t_ref += model_ratio(c);
            exp_q.push_back(t_ref);
            exp_tag.push_back(tg);
        end
        wait_ref();
    endtask

    // Code change in the middle of a period.
    task automatic play_mid(input logic [3:0] a, input logic [3:0] b, input int dly);
        code = a;
        t_ref += model_ratio(a);
        exp_q.push_back(t_ref); exp_tag.push_back("R5");
        t_ref += model_ratio(b);
        exp_q.push_back(t_ref); exp_tag.push_back("R5");
        repeat (dly) @(negedge clk);
        code = b;
        wait_ref();
    endtask

    task automatic check_low(input string tg);
        checks++;
        if (strobe !== 1'b0) begin
            failures++;
            $display("FAIL %s: strobe %b during reset, expected 0", tg, strobe);
        end
    endtask

    initial begin
        code = 4'd0;
        repeat (3) @(negedge clk);
        check_low("R6");
        // R4: first strobe after a full period of the code at release
        code = 4'd2;
        rst_n = 1'b1;
        t_ref = 0;
        play(4'd2, 3, "R4");
        // R1 and R7: every binary-family ratio, two periods each
        for (int s = 0; s < 8; s++) play(4'(s), 2, "R1");
        // R2 and R7: every five-family ratio
        for (int s = 8; s < 16; s++) play(4'(s), 2, "R2");
        // R5: mid-period changes in both directions
        play_mid(4'd3, 4'd8, 5);
        play_mid(4'd8, 4'd15, 1);
        play_mid(4'd10, 4'd0, 8);
        play(4'd0, 4, "R7");
        // R6: reset in the middle of a period
        code = 4'd3;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        exp_tag.delete();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_low("R6");
        end
        code = 4'd15;
        rst_n = 1'b1;
        t_ref = 0;
        play(4'd15, 2, "R6");
        play(4'd9, 3, "R7");
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R7: %0d strobes outstanding, expected 0", exp_q.size());
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule